// File: doc/BRIEF.md
# Real-Time Clock Register Block

A memory-mapped real-time clock on a plain 32-bit register port (request, write, byte address, write data, combinational read data). A sub-second counter counts pulses of a prescaled tick input; each time it passes its last value it wraps and the 32-bit seconds counter steps by one. Software can load the seconds counter, program an alarm, and read a fixed calibration value, the sub-second count and a control register.

Interrupts come in two groups. The time group has a seconds-step source and an alarm source. The address-error group flags accesses that hit no register. In each group the status bits are cleared by writing ones. The mask is read-only. It changes only through a pair of strobe registers, one that clears mask bits and one that sets them, so no read-modify-write of the mask is needed. Each group drives one interrupt line.

Top module: `rtc_regblock`

Register map (word offsets, aligned 32-bit little-endian accesses only): 0x00 time load (write loads seconds, read returns seconds), 0x04 time now (RO), 0x08 calibration (RO, 21 bits), 0x0C sub-second (RO, 16 bits), 0x10 alarm (RW), 0x14 control (RW), 0x18 time status (W1C, bit0 seconds, bit1 alarm), 0x1C time mask (RO), 0x20 time unmask strobe, 0x24 time mask-set strobe, 0x28 address-error status (W1C, bit0), 0x2C address-error mask (RO), 0x30 address-error unmask strobe, 0x34 address-error mask-set strobe.

## Requirements
- R1: After reset both interrupt lines are low, the time mask reads 0x3, the address-error mask reads 0x1, both status registers read 0, and control reads 0x01000000.
- R2: Each tick_i pulse advances the sub-second count (offset 0x0C, 16 bits). At TICKS_PER_SEC-1, the next pulse returns it to 0 and steps the seconds counter by one.
- R3: A write to offset 0x00 loads the seconds counter and clears the sub-second count. Offsets 0x00 and 0x04 both read the seconds count. The counter wraps from 0xFFFFFFFF to 0.
- R4: Every step of the seconds counter sets time status bit 0.
- R5: When the seconds counter steps onto the value held in the alarm register (offset 0x10), time status bit 1 is set.
- R6: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged. A source event in the same cycle takes priority over the clear.
- R7: Writing a 1 to a bit of an unmask strobe clears that mask bit, and writing a 1 to a mask-set strobe sets it. Strobe registers read 0. Writes to a mask register are ignored.
- R8: Each interrupt line is high exactly while some status bit of its group is set with the matching mask bit clear.
- R9: An access to an unmapped or misaligned address sets address-error status bit 0. Its write data is discarded, and its read returns 0.
- R10: The address-error group has its own W1C status, its own mask (reset 1) with unmask and mask-set strobes, and its own interrupt line, independent of the time group.
- R11: In the control register, the bits in 0x70FFFFFE read as zero and ignore writes. The other bits store what was written.
- R12: The calibration register reads the CALIB_INIT value in its low 21 bits, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaled tick pulse, one cycle wide |
| req_i | input | 1 | Access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the request cycle |
| irq_time_o | output | 1 | Time group interrupt |
| irq_aerr_o | output | 1 | Address-error group interrupt |

## Verification
The bench builds the block with TICKS_PER_SEC set to 4, so a full second takes four tick pulses. The sub-second wrap, seconds steps, alarm match and 32-bit rollover can then all be reached within a few dozen cycles. CALIB_INIT is set to a non-trivial 21-bit pattern, which makes a stuck or truncated calibration readback visible.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DATA_W = 32;
  localparam int NUM_REGS = 14;

  typedef enum logic [3:0] {
    REG_TIME_LOAD  = 4'd0,
    REG_TIME_NOW   = 4'd1,
    REG_CALIB      = 4'd2,
    REG_SUBSEC     = 4'd3,
    REG_ALARM      = 4'd4,
    REG_CTRL       = 4'd5,
    REG_T_STATUS   = 4'd6,
    REG_T_MASK     = 4'd7,
    REG_T_UNMASK   = 4'd8,
    REG_T_MASKSET  = 4'd9,
    REG_A_STATUS   = 4'd10,
    REG_A_MASK     = 4'd11,
    REG_A_UNMASK   = 4'd12,
    REG_A_MASKSET  = 4'd13
  } rtc_reg_e;

  localparam logic [DATA_W-1:0] CTRL_RESET = 32'h0100_0000;
  localparam logic [DATA_W-1:0] CTRL_RSVD  = 32'h70FF_FFFE;
endpackage

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int SUB_W = 16,
  parameter int SEC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [SEC_W-1:0] load_val_i,
  output logic [SEC_W-1:0] sec_o,
  output logic [SUB_W-1:0] sub_o,
  output logic             sec_step_o
);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_SEC - 1);

  logic [SEC_W-1:0] sec_q;
  logic [SUB_W-1:0] sub_q;
  logic             wrap;

  assign wrap       = tick_i && (sub_q == SUB_LAST);
  assign sec_step_o = wrap && !load_i;
  assign sec_o      = sec_q;
  assign sub_o      = sub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      sub_q <= '0;
    end else if (load_i) begin
      sec_q <= load_val_i;
      sub_q <= '0;
    end else if (tick_i) begin
      if (wrap) begin
        sub_q <= '0;
        sec_q <= sec_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && sub_q == SUB_LAST) |=> (sub_q == '0 && sec_q == $past(sec_q) + 1'b1));

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sec_q == $past(load_val_i) && sub_q == '0));
endmodule

// File: rtl/rtc_irq_group.sv
module rtc_irq_group #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic         unmask_we_i,
  input  logic         maskset_we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] status_q, mask_q;
  logic [N-1:0] clr;

  assign clr = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '1;
    end else begin
      status_q <= (status_q & ~clr) | set_i;
      if (unmask_we_i)       mask_q <= mask_q & ~wdata_i;
      else if (maskset_we_i) mask_q <= mask_q | wdata_i;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & ~mask_q);

  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((status_q & $past(set_i)) == $past(set_i)));

  p_unmask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmask_we_i |=> ((mask_q & $past(wdata_i)) == '0));

  p_maskset_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (maskset_we_i && !unmask_we_i) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));

  p_mask_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unmask_we_i && !maskset_we_i) |=> $stable(mask_q));
endmodule

// File: rtl/rtc_regblock.sv
module rtc_regblock
  import rtc_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter int          TICKS_PER_SEC = 32768,
  parameter logic [20:0] CALIB_INIT = 21'h00_8000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_time_o,
  output logic              irq_aerr_o
);
  localparam int SUB_W = 16;
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic              aligned, hit, wr, rd;
  rtc_reg_e          sel;

  logic [31:0]      sec;
  logic [SUB_W-1:0] sub;
  logic             sec_step, alarm_hit;
  logic [31:0]      alarm_q, ctrl_q;

  logic [1:0] t_status, t_mask;
  logic [0:0] a_status, a_mask;

  assign widx    = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign hit     = aligned && (widx < WIDX_W'(NUM_REGS));
  assign sel     = rtc_reg_e'(widx[3:0]);
  assign wr      = req_i && we_i && hit;
  assign rd      = req_i && !we_i && hit;

  rtc_counter #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .SUB_W(SUB_W),
    .SEC_W(32)
  ) i_counter (
    .clk_i(clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .load_i(wr && sel == REG_TIME_LOAD),
    .load_val_i(wdata_i),
    .sec_o(sec),
    .sub_o(sub),
    .sec_step_o(sec_step)
  );

  assign alarm_hit = sec_step && ((sec + 1'b1) == alarm_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_q <= '0;
      ctrl_q  <= CTRL_RESET;
    end else if (wr) begin
      if (sel == REG_ALARM) alarm_q <= wdata_i;
      if (sel == REG_CTRL)  ctrl_q  <= wdata_i & ~CTRL_RSVD;
    end
  end

  rtc_irq_group #(.N(2)) i_time_irq (
    .clk_i(clk_i),
    .rst_ni(rst_ni),
    .set_i({alarm_hit, sec_step}),
    .clr_we_i(wr && sel == REG_T_STATUS),
    .unmask_we_i(wr && sel == REG_T_UNMASK),
    .maskset_we_i(wr && sel == REG_T_MASKSET),
    .wdata_i(wdata_i[1:0]),
    .status_o(t_status),
    .mask_o(t_mask),
    .irq_o(irq_time_o)
  );

  rtc_irq_group #(.N(1)) i_aerr_irq (
    .clk_i(clk_i),
    .rst_ni(rst_ni),
    .set_i(req_i && !hit),
    .clr_we_i(wr && sel == REG_A_STATUS),
    .unmask_we_i(wr && sel == REG_A_UNMASK),
    .maskset_we_i(wr && sel == REG_A_MASKSET),
    .wdata_i(wdata_i[0:0]),
    .status_o(a_status),
    .mask_o(a_mask),
    .irq_o(irq_aerr_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (sel)
        REG_TIME_LOAD, REG_TIME_NOW: rdata_o = sec;
        REG_CALIB:    rdata_o = {11'd0, CALIB_INIT};
        REG_SUBSEC:   rdata_o = {16'd0, sub};
        REG_ALARM:    rdata_o = alarm_q;
        REG_CTRL:     rdata_o = ctrl_q;
        REG_T_STATUS: rdata_o = {30'd0, t_status};
        REG_T_MASK:   rdata_o = {30'd0, t_mask};
        REG_A_STATUS: rdata_o = {31'd0, a_status};
        REG_A_MASK:   rdata_o = {31'd0, a_mask};
        default:      rdata_o = '0;
      endcase
    end
  end

  p_aerr_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !hit) |=> a_status[0]);

  p_ctrl_rsvd_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q & CTRL_RSVD) == '0);

  p_alarm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_step && !(wr && sel == REG_ALARM) && (sec + 1'b1) == alarm_q) |=> t_status[1]);
endmodule

// File: tb/test_rtc_regblock.sv
module test_rtc_regblock;
  localparam int          ADDR_W = 8;
  localparam int          TPS = 4;
  localparam logic [20:0] CAL = 21'h1A_5A5A;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_time_o, irq_aerr_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rtc_regblock #(.ADDR_W(ADDR_W), .TICKS_PER_SEC(TPS), .CALIB_INIT(CAL)) i_rtc_regblock (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irq_time_o(irq_time_o), .irq_aerr_o(irq_aerr_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1", "irq_time", {31'd0, irq_time_o}, 32'd0);
    chk("R1", "irq_aerr", {31'd0, irq_aerr_o}, 32'd0);
    rd(8'h1C, v); chk("R1", "time mask", v, 32'h3);
    rd(8'h2C, v); chk("R1", "aerr mask", v, 32'h1);
    rd(8'h18, v); chk("R1", "time status", v, 32'h0);
    rd(8'h28, v); chk("R1", "aerr status", v, 32'h0);
    rd(8'h14, v); chk("R1", "ctrl", v, 32'h0100_0000);
  endtask

  task automatic t_ticks;
    logic [31:0] v;
    ticks(TPS - 1);
    rd(8'h0C, v); chk("R2", "subsec before wrap", v, TPS - 1);
    rd(8'h04, v); chk("R2", "sec before wrap", v, 32'd0);
    rd(8'h18, v); chk("R4", "no step yet", v, 32'd0);
    ticks(1);
    rd(8'h0C, v); chk("R2", "subsec after wrap", v, 32'd0);
    rd(8'h04, v); chk("R2", "sec after wrap", v, 32'd1);
    rd(8'h18, v); chk("R4", "seconds status", v, 32'h1);
  endtask

  task automatic t_load_wrap;
    logic [31:0] v;
    wr(8'h10, 32'd5);
    ticks(2);
    wr(8'h00, 32'hFFFF_FFFE);
    rd(8'h0C, v); chk("R3", "subsec cleared by load", v, 32'd0);
    rd(8'h04, v); chk("R3", "now after load", v, 32'hFFFF_FFFE);
    rd(8'h00, v); chk("R3", "load reg readback", v, 32'hFFFF_FFFE);
    ticks(TPS);
    rd(8'h04, v); chk("R3", "now 0xFFFFFFFF", v, 32'hFFFF_FFFF);
    ticks(TPS);
    rd(8'h00, v); chk("R3", "wrap to 0", v, 32'd0);
  endtask

  task automatic t_alarm;
    logic [31:0] v;
    wr(8'h00, 32'd9);
    wr(8'h10, 32'd10);
    wr(8'h18, 32'h3);
    rd(8'h18, v); chk("R6", "status cleared", v, 32'd0);
    ticks(TPS);
    rd(8'h04, v); chk("R5", "sec at alarm", v, 32'd10);
    rd(8'h18, v); chk("R5", "alarm+seconds status", v, 32'h3);
    chk("R8", "masked irq low", {31'd0, irq_time_o}, 32'd0);
  endtask

  task automatic t_w1c_irq;
    logic [31:0] v;
    wr(8'h20, 32'h2);
    rd(8'h1C, v); chk("R7", "unmask bit1", v, 32'h1);
    chk("R8", "alarm irq high", {31'd0, irq_time_o}, 32'd1);
    wr(8'h18, 32'h2);
    rd(8'h18, v); chk("R6", "w1c bit1 only", v, 32'h1);
    chk("R8", "irq low, bit0 masked", {31'd0, irq_time_o}, 32'd0);
    wr(8'h20, 32'h1);
    chk("R8", "seconds irq high", {31'd0, irq_time_o}, 32'd1);
    wr(8'h18, 32'h0);
    rd(8'h18, v); chk("R6", "w0 no effect", v, 32'h1);
    wr(8'h18, 32'h1);
    chk("R8", "irq low after clear", {31'd0, irq_time_o}, 32'd0);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    wr(8'h1C, 32'h3);
    rd(8'h1C, v); chk("R7", "mask write ignored", v, 32'h0);
    rd(8'h20, v); chk("R7", "unmask reads 0", v, 32'h0);
    rd(8'h24, v); chk("R7", "maskset reads 0", v, 32'h0);
    wr(8'h24, 32'h3);
    rd(8'h1C, v); chk("R7", "maskset sets both", v, 32'h3);
  endtask

  task automatic t_addr_err;
    logic [31:0] v;
    rd(8'h40, v); chk("R9", "unmapped read zero", v, 32'd0);
    rd(8'h28, v); chk("R9", "aerr status set", v, 32'h1);
    chk("R10", "aerr masked", {31'd0, irq_aerr_o}, 32'd0);
    wr(8'h30, 32'h1);
    rd(8'h2C, v); chk("R10", "aerr unmasked", v, 32'h0);
    chk("R10", "aerr irq high", {31'd0, irq_aerr_o}, 32'd1);
    chk("R10", "time irq unaffected", {31'd0, irq_time_o}, 32'd0);
    wr(8'h11, 32'hDEAD_BEEF);
    rd(8'h10, v); chk("R9", "misaligned write dropped", v, 32'd10);
    wr(8'h28, 32'h1);
    rd(8'h28, v); chk("R10", "aerr w1c", v, 32'h0);
    chk("R10", "aerr irq low", {31'd0, irq_aerr_o}, 32'd0);
    wr(8'h34, 32'h1);
    rd(8'h2C, v); chk("R10", "aerr mask set", v, 32'h1);
  endtask

  task automatic t_ctrl;
    logic [31:0] v;
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, v); chk("R11", "ctrl ones", v, 32'h8F00_0001);
    wr(8'h14, 32'h0);
    rd(8'h14, v); chk("R11", "ctrl zero", v, 32'h0);
  endtask

  task automatic t_calib;
    logic [31:0] v;
    rd(8'h08, v); chk("R12", "calib value", v, {11'd0, CAL});
    wr(8'h08, 32'h0);
    rd(8'h08, v); chk("R12", "calib write ignored", v, {11'd0, CAL});
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_ticks();
    t_load_wrap();
    t_alarm();
    t_w1c_irq();
    t_mask();
    t_addr_err();
    t_ctrl();
    t_calib();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule